// File: doc/BRIEF.md
# Receive Descriptor Status Writeback

This block builds the 32-bit status word that a receive DMA engine writes back into a host descriptor. A received frame may occupy several descriptor buffers. The engine reports each data beat with its byte count and signals when a buffer is full or when the frame ends. On each of those events the block emits one status word with a one-cycle write strobe. The word hands the descriptor back to the host by clearing its ownership bit.

The length field carries a running byte total for the whole frame and does not restart at buffer boundaries. On the final descriptor it holds the frame length, including two bytes when checksum offload appends them. Error flags from any beat of the frame are collected and shown, together with their summary bit, only on the descriptor that closes the frame. Memory-bus transfers, descriptor chaining and CRC or checksum computation are left to neighbouring blocks.

Top module: `rx_status_wb`

## Requirements
- R1: After reset `wb_vld` is 0 and `wb_word` is all zeros.
- R2: A cycle with `buf_full` or `frame_end` high gives exactly one `wb_vld` pulse in the next cycle. No other cycle produces one. Every emitted word has bit 31 (ownership) at 0.
- R3: Bits 29:16 hold the sum of `beat_bytes` over all beats with `beat_vld` high since the frame started, up to and including the strobe cycle. The sum runs across descriptor boundaries, and a beat with `beat_vld` low adds nothing.
- R4: The cycle after a `frame_end` cycle begins a new frame, and its running length starts from zero.
- R5: On the final descriptor the length includes 2 extra bytes when `csum_en` is 1 and `ctl_frame` is 0 in the `frame_end` cycle. In any other case no bytes are added.
- R6: The length saturates at 16383 (14 bits) and does not wrap.
- R7: Bit 8 (last descriptor) is 1 exactly when the strobe cycle had `frame_end` high. When `buf_full` and `frame_end` are high together, one writeback is issued and it has bit 8 set.
- R8: Error flags are collected over the whole frame and reported only on the last descriptor, at these positions: CRC bit 1, receive bit 3, watchdog bit 4, late collision bit 6, giant bit 7, overflow bit 11, descriptor bit 14. On a non-last descriptor, bits 1, 3, 4, 6, 7, 11, 14 and 15 are 0.
- R9: On the last descriptor, bit 15 is the OR of all collected error flags, including the two `ip_err` bits. The `ip_err` bits have no position of their own in the word.
- R10: Bit 30 is 1 on every writeback of a frame once `da_fail` has been seen high in any cycle of that frame so far.
- R11: Bits 0, 2, 5, 9, 10, 12 and 13 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_vld | input | 1 | A data beat is transferred this cycle |
| beat_bytes | input | 8 | Byte count of the beat |
| buf_full | input | 1 | Current descriptor buffer is full |
| frame_end | input | 1 | Frame ends with this cycle |
| da_fail | input | 1 | Destination-address filter rejected the frame |
| err_crc | input | 1 | CRC error |
| err_rx | input | 1 | Receive error |
| err_wdt | input | 1 | Receive watchdog timeout |
| err_latecol | input | 1 | Late collision |
| err_giant | input | 1 | Giant frame |
| err_ovf | input | 1 | Overflow error |
| err_desc | input | 1 | Descriptor error |
| ip_err | input | 2 | IP header and payload error flags |
| csum_en | input | 1 | Checksum offload that appends two bytes is on |
| ctl_frame | input | 1 | Frame is a MAC control frame |
| wb_vld | output | 1 | Status word write strobe |
| wb_word | output | 32 | Status word |

## Verification
The main sweep runs frames of one to three descriptors with one to three beats each, under all four combinations of `csum_en` and `ctl_frame`. This separates a length that accumulates across buffers from one that restarts, and shows whether the pad is applied only on the last descriptor of non-control frames. Each error flag is then raised alone in the first descriptor of a two-descriptor frame. That checks its bit position, that it stays hidden until the last descriptor, and that the summary bit covers it, including the two IP flags. Further runs cover a frame long enough to saturate the counter and the frame after it, a combined buffer-full and end-of-frame strobe, and a strobe carrying a byte count with `beat_vld` low.

// File: rtl/rx_wb_pkg.sv
package rx_wb_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned P_OWN    = 31;
    localparam int unsigned P_DAF    = 30;
    localparam int unsigned P_LEN_LO = 16;
    localparam int unsigned P_ES     = 15;
    localparam int unsigned P_DESC   = 14;
    localparam int unsigned P_OVF    = 11;
    localparam int unsigned P_LAST   = 8;
    localparam int unsigned P_GIANT  = 7;
    localparam int unsigned P_LCOL   = 6;
    localparam int unsigned P_WDT    = 4;
    localparam int unsigned P_RXE    = 3;
    localparam int unsigned P_CRC    = 1;

    typedef struct packed {
        logic [1:0] ip;
        logic       desc;
        logic       ovf;
        logic       giant;
        logic       lcol;
        logic       wdt;
        logic       rxe;
        logic       crc;
    } err_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } wb_t;
endpackage

// File: rtl/rx_len_acc.sv
module rx_len_acc #(
    parameter int unsigned LEN_W  = 14,
    parameter int unsigned BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic              pad_add,
    input  logic              frame_end,
    output logic [LEN_W-1:0]  len_now
);
    localparam int unsigned SUM_W   = LEN_W + 1;
    localparam logic [SUM_W-1:0] LEN_MAX = SUM_W'((1 << LEN_W) - 1);

    logic [LEN_W-1:0] len_d, len_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, len_q};
        if (beat_vld) sum = sum + SUM_W'(beat_bytes);
        if (pad_add)  sum = sum + SUM_W'(2);
        len_now = (sum > LEN_MAX) ? LEN_MAX[LEN_W-1:0] : sum[LEN_W-1:0];
        len_d   = frame_end ? '0 : len_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end
endmodule

// File: rtl/rx_err_acc.sv
module rx_err_acc
    import rx_wb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  err_t err_in,
    input  logic da_in,
    input  logic frame_end,
    output err_t err_now,
    output logic da_now
);
    typedef struct packed {
        err_t err;
        logic da;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        err_now = acc_q.err | err_in;
        da_now  = acc_q.da | da_in;
        acc_d   = frame_end ? '0 : acc_t'{err: err_now, da: da_now};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/rx_status_fmt.sv
module rx_status_fmt
    import rx_wb_pkg::*;
#(
    parameter int unsigned LEN_W = 14
) (
    input  logic [LEN_W-1:0]  len,
    input  err_t              err,
    input  logic              da,
    input  logic              last,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = '0;
        word[P_OWN] = 1'b0;
        word[P_DAF] = da;
        word[P_LEN_LO +: LEN_W] = len;
        if (last) begin
            word[P_LAST]  = 1'b1;
            word[P_CRC]   = err.crc;
            word[P_RXE]   = err.rxe;
            word[P_WDT]   = err.wdt;
            word[P_LCOL]  = err.lcol;
            word[P_GIANT] = err.giant;
            word[P_OVF]   = err.ovf;
            word[P_DESC]  = err.desc;
            word[P_ES]    = |err;
        end
    end
endmodule

// File: rtl/rx_status_wb.sv
module rx_status_wb
    import rx_wb_pkg::*;
#(
    parameter int unsigned LEN_W  = 14,
    parameter int unsigned BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic              buf_full,
    input  logic              frame_end,
    input  logic              da_fail,
    input  logic              err_crc,
    input  logic              err_rx,
    input  logic              err_wdt,
    input  logic              err_latecol,
    input  logic              err_giant,
    input  logic              err_ovf,
    input  logic              err_desc,
    input  logic [1:0]        ip_err,
    input  logic              csum_en,
    input  logic              ctl_frame,
    output logic              wb_vld,
    output logic [31:0]       wb_word
);
    logic [LEN_W-1:0]  len_now;
    logic [WORD_W-1:0] fmt_word;
    logic              pad_add;
    logic              da_now;
    err_t              err_in, err_now;
    wb_t               st_d, st_q;

    assign pad_add = frame_end & csum_en & ~ctl_frame;
    assign err_in  = '{ip: ip_err, desc: err_desc, ovf: err_ovf, giant: err_giant,
                       lcol: err_latecol, wdt: err_wdt, rxe: err_rx, crc: err_crc};

    rx_len_acc #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_len (
        .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .beat_bytes(beat_bytes),
        .pad_add(pad_add), .frame_end(frame_end), .len_now(len_now)
    );

    rx_err_acc u_err (
        .clk(clk), .rst_n(rst_n), .err_in(err_in), .da_in(da_fail),
        .frame_end(frame_end), .err_now(err_now), .da_now(da_now)
    );

    rx_status_fmt #(.LEN_W(LEN_W)) u_fmt (
        .len(len_now), .err(err_now), .da(da_now), .last(frame_end), .word(fmt_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = buf_full | frame_end;
        if (st_d.vld) st_d.word = fmt_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_vld  = st_q.vld;
    assign wb_word = st_q.word;
endmodule

// File: rtl/rx_status_wb_chk.sv
module rx_status_wb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        buf_full,
    input logic        frame_end,
    input logic        wb_vld,
    input logic [31:0] wb_word
);
    localparam logic [31:0] ERR_BITS = 32'h0000_48DA;
    localparam logic [31:0] ERR_ES   = 32'h0000_C8DA;
    localparam logic [31:0] RSVD     = 32'h0000_3625;

    AST_WB_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full || frame_end) |=> wb_vld); // R2
    AST_WB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_full || frame_end) |=> !wb_vld); // R2
    AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> !wb_word[31]); // R2
    AST_LAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full || frame_end) |=> (wb_word[8] == $past(frame_end))); // R7
    AST_NONLAST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && !wb_word[8]) |-> ((wb_word & ERR_ES) == 32'h0)); // R8
    AST_ES_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && ((wb_word & ERR_BITS) != 32'h0)) |-> wb_word[15]); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> ((wb_word & RSVD) == 32'h0)); // R11
endmodule

bind rx_status_wb rx_status_wb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .frame_end(frame_end),
    .wb_vld(wb_vld), .wb_word(wb_word)
);

// File: tb/sim_rx_status_wb.sv
module sim_rx_status_wb;
    logic        clk = 0, rst_n = 0;
    logic        beat_vld = 0, buf_full = 0, frame_end = 0, da_fail = 0;
    logic [7:0]  beat_bytes = 0;
    logic        err_crc = 0, err_rx = 0, err_wdt = 0, err_latecol = 0;
    logic        err_giant = 0, err_ovf = 0, err_desc = 0;
    logic [1:0]  ip_err = 0;
    logic        csum_en = 0, ctl_frame = 0;
    logic        wb_vld;
    logic [31:0] wb_word;

    int checks = 0, errors = 0;
    int m_len = 0;
    logic [8:0] m_err = 0;
    bit m_da = 0;

    always #5 clk = ~clk;

    rx_status_wb u0 (
        .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .beat_bytes(beat_bytes),
        .buf_full(buf_full), .frame_end(frame_end), .da_fail(da_fail),
        .err_crc(err_crc), .err_rx(err_rx), .err_wdt(err_wdt), .err_latecol(err_latecol),
        .err_giant(err_giant), .err_ovf(err_ovf), .err_desc(err_desc), .ip_err(ip_err),
        .csum_en(csum_en), .ctl_frame(ctl_frame), .wb_vld(wb_vld), .wb_word(wb_word)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // e: [0]crc [1]rx [2]wdt [3]latecol [4]giant [5]ovf [6]desc [8:7]ip
    function automatic logic [31:0] mk(int len, bit last, logic [8:0] e, bit da);
        logic [31:0] w;
        w = '0;
        w[30] = da;
        w[29:16] = len[13:0];
        if (last) begin
            w[8] = 1; w[1] = e[0]; w[3] = e[1]; w[4] = e[2]; w[6] = e[3];
            w[7] = e[4]; w[11] = e[5]; w[14] = e[6]; w[15] = |e;
        end
        return w;
    endfunction

    task automatic step(int bytes, bit vld, bit bf, bit fe, logic [8:0] e, bit da, string tag);
        logic [31:0] exp;
        bit strobe;
        beat_vld = vld; beat_bytes = bytes[7:0]; buf_full = bf; frame_end = fe;
        err_crc = e[0]; err_rx = e[1]; err_wdt = e[2]; err_latecol = e[3];
        err_giant = e[4]; err_ovf = e[5]; err_desc = e[6]; ip_err = e[8:7]; da_fail = da;
        if (vld) m_len += bytes;
        if (fe && csum_en && !ctl_frame) m_len += 2;
        if (m_len > 16383) m_len = 16383;
        m_err |= e; m_da |= da;
        strobe = bf | fe;
        exp = mk(m_len, fe, m_err, m_da);
        @(posedge clk); @(negedge clk);
        beat_vld = 0; buf_full = 0; frame_end = 0; da_fail = 0;
        {err_crc, err_rx, err_wdt, err_latecol, err_giant, err_ovf, err_desc} = '0;
        ip_err = 0;
        chk(wb_vld == strobe, {tag, " R2 strobe"}, 32'(wb_vld), 32'(strobe));
        if (strobe) chk(wb_word == exp, {tag, " word"}, wb_word, exp);
        if (fe) begin m_len = 0; m_err = 0; m_da = 0; end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(wb_vld == 0 && wb_word == 0, "R1 reset", wb_word, 0);
        rst_n = 1;
        @(negedge clk);
        chk(wb_vld == 0, "R1 after release", 32'(wb_vld), 0);

        // R3 R5 R7 sweep over descriptor count, beat count and offload modes
        for (int nd = 1; nd <= 3; nd++)
            for (int nb = 1; nb <= 3; nb++)
                for (int mode = 0; mode < 4; mode++) begin
                    csum_en = mode[0]; ctl_frame = mode[1];
                    for (int d = 0; d < nd; d++)
                        for (int b = 0; b < nb; b++) begin
                            bit endd = (b == nb - 1);
                            bit endf = endd && (d == nd - 1);
                            step((d * 37 + b * 101 + nd * 13 + mode * 7) % 256, 1,
                                 endd && !endf, endf, '0, 0, "R3 R5 sweep");
                        end
                end
        csum_en = 0; ctl_frame = 0;

        // R7 simultaneous buffer full and frame end
        step(40, 1, 0, 0, '0, 0, "R7 lead");
        step(60, 1, 1, 1, '0, 0, "R7 combined");
        step(10, 1, 0, 0, '0, 0, "R7 quiet");
        step(5, 1, 0, 1, '0, 0, "R7 tail");

        // R8 R9 each error alone, in the first descriptor of two
        for (int k = 0; k < 9; k++) begin
            step(20, 1, 1, 0, 9'(1 << k), 0, "R8 nonlast");
            step(30, 1, 0, 1, '0, 0, "R8 R9 last");
        end

        // R10 address filter failure sticky over the frame
        step(12, 1, 0, 0, '0, 1, "R10 seen");
        step(12, 1, 1, 0, '0, 0, "R10 desc1");
        step(12, 1, 0, 1, '0, 0, "R10 last");
        step(12, 1, 0, 1, '0, 0, "R10 next frame clear");

        // R6 saturation, then R4 restart
        csum_en = 1;
        for (int i = 0; i < 70; i++)
            step(255, 1, (i % 10 == 9) && (i != 69), i == 69, '0, 0, "R6 sat");
        csum_en = 0;
        step(9, 1, 0, 1, '0, 0, "R4 restart");

        // R3 byte count with beat_vld low adds nothing
        step(200, 0, 1, 0, '0, 0, "R3 novld");
        step(3, 1, 0, 1, '0, 0, "R3 novld last");

        // R11 reserved bits are covered by the exact word compares above
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule